// File: doc/BRIEF.md
# Morse Key Character Decoder

This block turns a hand-operated Morse key into characters. The key arrives as a raw, bouncing level on a 100 MHz clock. The block brings the key into the clock domain, filters out contact bounce, and measures how long each press lasts. Each press is classified as a short element or a long element against a threshold set by the dot unit.

Elements are collected as a walk down the Morse binary tree: a short element steps left and a long element steps right. When the key stays released long enough, the walk is translated into an ASCII letter or digit. The block then presents one byte with a single-cycle strobe, ready for a serial transmitter.

Sequences that are too long, or that end on a node with no character, are dropped without output. The dot unit and the debounce window are parameters, so the same logic serves any keying speed.

Top module: `morse_char_decoder`

## Requirements
- R1: The raw key passes through a two-flop synchroniser; a change of the synchronised key reaches the timing logic only after it has held for DEBOUNCE_CYCLES consecutive cycles, so a shorter pulse produces no character.
- R2: Each press is timed by an element state machine stepping idle, press, hold, release, store in that order; a press shorter than 2*DOT_CYCLES is a short element, one of 2*DOT_CYCLES or longer is a long element, and an arbitrarily long press stays a long element.
- R3: A released interval shorter than 3*DOT_CYCLES keeps the following element in the same character; a released interval of 3*DOT_CYCLES or more closes the character.
- R4: The tree path (a leading 1, then 0 per short and 1 per long element) maps the 26 international letter codes to upper-case ASCII 0x41 to 0x5A.
- R5: The ten five-element digit codes map to ASCII 0x30 to 0x39.
- R6: A character with more than 5 elements gives no output byte and clears the collected path, so the next character decodes normally.
- R7: A path of at most 5 elements with no letter or digit (for example short-short-long-long) gives no output byte and clears the collected path.
- R8: char_valid is high for exactly one cycle per decoded character, and char_ascii holds its value until the next strobe.
- R9: After reset char_valid is 0 and char_ascii is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| key_raw | input | 1 | Unsynchronised Morse key, 1 = pressed |
| char_ascii | output | 8 | Last decoded character, ASCII |
| char_valid | output | 1 | One-cycle strobe marking a new char_ascii |

## Verification
The hardest case to reach from the ports is a press or a gap that lands just either side of its threshold. Every edge first crosses the synchroniser and the debounce counter and then the state machine's entry and exit states, so the length seen inside differs from the driven one by a few cycles. The bench shrinks the dot unit to 16 cycles and the debounce window to 4. It then drives presses and gaps a few cycles inside each side of the 2-unit and 3-unit limits and sees the difference only as a different character, or a different number of characters. Overlong and unmapped paths are each followed by a valid character, to show that the path was cleared.

// File: rtl/morse_pkg.sv
package morse_pkg;

  // Tree depth supported by the character table
  localparam int unsigned MAX_ELEMS = 5;
  localparam int unsigned PATH_W    = MAX_ELEMS + 1;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRESS   = 3'd1,
    ST_HOLD    = 3'd2,
    ST_RELEASE = 3'd3,
    ST_STORE   = 3'd4
  } elem_state_t;

  typedef struct packed {
    logic       hit;
    logic [7:0] code;
  } morse_sym_t;

  // Long element when the held time reaches two dot units
  function automatic logic elem_is_long(input int unsigned held, input int unsigned unit);
    return held >= 2 * unit;
  endfunction

  // Character closes once the released time reaches three dot units
  function automatic logic gap_is_closing(input int unsigned idle, input int unsigned unit);
    return idle >= 3 * unit;
  endfunction

  function automatic logic is_alnum(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h5A);
  endfunction

  // Path: leading 1 marker, then 0 = short (left), 1 = long (right)
  function automatic morse_sym_t path_to_ascii(input logic [PATH_W-1:0] p);
    morse_sym_t r;
    r.hit  = 1'b1;
    r.code = 8'h00;
    case (p)
      6'd2:  r.code = "E";
      6'd3:  r.code = "T";
      6'd4:  r.code = "I";
      6'd5:  r.code = "A";
      6'd6:  r.code = "N";
      6'd7:  r.code = "M";
      6'd8:  r.code = "S";
      6'd9:  r.code = "U";
      6'd10: r.code = "R";
      6'd11: r.code = "W";
      6'd12: r.code = "D";
      6'd13: r.code = "K";
      6'd14: r.code = "G";
      6'd15: r.code = "O";
      6'd16: r.code = "H";
      6'd17: r.code = "V";
      6'd18: r.code = "F";
      6'd20: r.code = "L";
      6'd22: r.code = "P";
      6'd23: r.code = "J";
      6'd24: r.code = "B";
      6'd25: r.code = "X";
      6'd26: r.code = "C";
      6'd27: r.code = "Y";
      6'd28: r.code = "Z";
      6'd29: r.code = "Q";
      6'd32: r.code = "5";
      6'd33: r.code = "4";
      6'd35: r.code = "3";
      6'd39: r.code = "2";
      6'd47: r.code = "1";
      6'd48: r.code = "6";
      6'd56: r.code = "7";
      6'd60: r.code = "8";
      6'd62: r.code = "9";
      6'd63: r.code = "0";
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/morse_key_filter.sv
module morse_key_filter #(
  parameter int unsigned DEBOUNCE_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_raw,
  output logic key_level
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] stable_cnt;
  logic          key_sync;

  assign key_sync = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= 2'b00;
      key_level  <= 1'b0;
      stable_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], key_raw};
      if (key_sync != key_level) begin
        if (stable_cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
          key_level  <= key_sync;
          stable_cnt <= '0;
        end else begin
          stable_cnt <= stable_cnt + 1'b1;
        end
      end else begin
        stable_cnt <= '0;
      end
    end
  end

  AST_LEVEL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (key_level != $past(key_level)) |-> ($past(key_sync) == key_level)); // R1

endmodule

// File: rtl/morse_element_fsm.sv
module morse_element_fsm
  import morse_pkg::*;
#(
  parameter int unsigned DOT_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_level,
  output logic elem_strobe,
  output logic elem_long,
  output logic gap_expire
);
  localparam int unsigned LONG_MIN = 2 * DOT_CYCLES;
  localparam int unsigned GAP_MIN  = 3 * DOT_CYCLES;
  localparam int unsigned HW       = $clog2(LONG_MIN + 1);
  localparam int unsigned GW       = $clog2(GAP_MIN + 1);

  elem_state_t   state_q;
  logic [HW-1:0] hold_cnt;
  logic [GW-1:0] gap_cnt;
  logic          armed_q;
  logic          long_q;

  assign gap_expire  = (state_q == ST_IDLE) && !key_level && armed_q &&
                       gap_is_closing(32'(gap_cnt) + 1, DOT_CYCLES);
  assign elem_strobe = (state_q == ST_STORE);
  assign elem_long   = long_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hold_cnt <= '0;
      gap_cnt  <= '0;
      armed_q  <= 1'b0;
      long_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (key_level) begin
            state_q <= ST_PRESS;
            gap_cnt <= '0;
          end else if (armed_q) begin
            if (gap_expire) begin
              armed_q <= 1'b0;
              gap_cnt <= '0;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        ST_PRESS: begin
          hold_cnt <= HW'(1);
          state_q  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (key_level) begin
            if (32'(hold_cnt) < LONG_MIN) hold_cnt <= hold_cnt + 1'b1;
          end else begin
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          long_q  <= elem_is_long(32'(hold_cnt), DOT_CYCLES);
          state_q <= ST_STORE;
        end
        ST_STORE: begin
          armed_q <= 1'b1;
          gap_cnt <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_PRESS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRESS) |-> ($past(state_q) == ST_IDLE)); // R2
  AST_RELEASE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE) |-> ($past(state_q) == ST_HOLD)); // R2
  AST_STORE_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE) |-> ($past(state_q) == ST_RELEASE)); // R2
  AST_HOLD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> (hold_cnt >= $past(hold_cnt))); // R2
  AST_GAP_NEEDS_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expire |-> !elem_strobe); // R3

endmodule

// File: rtl/morse_path_decoder.sv
module morse_path_decoder
  import morse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       elem_strobe,
  input  logic       elem_long,
  input  logic       gap_expire,
  output logic [7:0] char_ascii,
  output logic       char_valid
);
  localparam int unsigned CW = $clog2(MAX_ELEMS + 2);

  logic [PATH_W-1:0] path_q;
  logic [CW-1:0]     elem_cnt;
  logic              too_long;
  morse_sym_t        sym;

  assign too_long = (32'(elem_cnt) > MAX_ELEMS);
  assign sym      = path_to_ascii(path_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      path_q     <= PATH_W'(1);
      elem_cnt   <= '0;
      char_ascii <= 8'h00;
      char_valid <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (gap_expire) begin
        if (!too_long && sym.hit) begin
          char_ascii <= sym.code;
          char_valid <= 1'b1;
        end
        path_q   <= PATH_W'(1);
        elem_cnt <= '0;
      end else if (elem_strobe) begin
        if (32'(elem_cnt) < MAX_ELEMS) begin
          path_q   <= {path_q[PATH_W-2:0], elem_long};
          elem_cnt <= elem_cnt + 1'b1;
        end else begin
          elem_cnt <= CW'(MAX_ELEMS + 1);
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid); // R8
  AST_ASCII_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> $stable(char_ascii)); // R8
  AST_ONLY_ALNUM: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> is_alnum(char_ascii)); // R4
  AST_ELEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(elem_cnt) <= MAX_ELEMS + 1); // R6
  AST_OVERLONG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expire && too_long) |=> !char_valid); // R6
  AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expire && !sym.hit) |=> !char_valid); // R7

endmodule

// File: rtl/morse_char_decoder.sv
module morse_char_decoder
  import morse_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 1_000_000,
  parameter int unsigned DOT_CYCLES      = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_raw,
  output logic [7:0] char_ascii,
  output logic       char_valid
);
  logic key_level;
  logic elem_strobe;
  logic elem_long;
  logic gap_expire;

  morse_key_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_raw   (key_raw),
    .key_level (key_level)
  );

  morse_element_fsm #(.DOT_CYCLES(DOT_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_level   (key_level),
    .elem_strobe (elem_strobe),
    .elem_long   (elem_long),
    .gap_expire  (gap_expire)
  );

  morse_path_decoder u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .elem_strobe (elem_strobe),
    .elem_long   (elem_long),
    .gap_expire  (gap_expire),
    .char_ascii  (char_ascii),
    .char_valid  (char_valid)
  );

endmodule

// File: tb/tb_morse_char_decoder.sv
module tb_morse_char_decoder;
  localparam int DEB  = 4;
  localparam int UNIT = 16;
  localparam int SHORT_LEN = 12;
  localparam int LONG_LEN  = 48;
  localparam int INTRA_GAP = 20;
  localparam int CHAR_WAIT = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_raw = 1'b0;
  logic [7:0] char_ascii;
  logic       char_valid;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int doubles = 0;
  logic [7:0] codes [0:7];
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  morse_char_decoder #(.DEBOUNCE_CYCLES(DEB), .DOT_CYCLES(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw),
    .char_ascii(char_ascii), .char_valid(char_valid)
  );

  always @(negedge clk) begin
    if (char_valid) begin
      if (vcount < 8) codes[vcount] = char_ascii;
      vcount = vcount + 1;
      if (prev_valid) doubles = doubles + 1;
    end
    prev_valid = char_valid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic elem(input int hold, input int gap);
    key_raw = 1'b1;
    repeat (hold) @(negedge clk);
    key_raw = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send(input string s);
    for (int i = 0; i < s.len(); i++)
      elem((s[i] == 8'h2D) ? LONG_LEN : SHORT_LEN, INTRA_GAP);
    repeat (CHAR_WAIT) @(negedge clk);
  endtask

  task automatic clear_mon();
    vcount = 0;
    doubles = 0;
  endtask

  task automatic expect_one(input string tag, input string s, input logic [7:0] exp);
    clear_mon();
    send(s);
    check(vcount == 1, {tag, " count ", s}, vcount, 1);
    check(codes[0] == exp, {tag, " code ", s}, int'(codes[0]), int'(exp));
  endtask

  task automatic t_reset();
    check(char_valid == 1'b0, "R9 valid after reset", int'(char_valid), 0);
    check(char_ascii == 8'h00, "R9 ascii after reset", int'(char_ascii), 0);
  endtask

  task automatic t_classify();
    expect_one("R2", ".", "E");
    expect_one("R2", "-", "T");
    clear_mon();
    elem(2 * UNIT - 4, INTRA_GAP);
    repeat (CHAR_WAIT) @(negedge clk);
    check(vcount == 1 && codes[0] == "E", "R2 just below threshold", int'(codes[0]), "E");
    clear_mon();
    elem(2 * UNIT + 4, INTRA_GAP);
    repeat (CHAR_WAIT) @(negedge clk);
    check(vcount == 1 && codes[0] == "T", "R2 just above threshold", int'(codes[0]), "T");
    clear_mon();
    elem(40 * UNIT, INTRA_GAP);
    repeat (CHAR_WAIT) @(negedge clk);
    check(vcount == 1 && codes[0] == "T", "R2 very long press", int'(codes[0]), "T");
  endtask

  task automatic t_gap();
    clear_mon();
    elem(SHORT_LEN, 3 * UNIT - 8);
    elem(SHORT_LEN, CHAR_WAIT);
    check(vcount == 1 && codes[0] == "I", "R3 short gap joins", int'(codes[0]), "I");
    clear_mon();
    elem(SHORT_LEN, 3 * UNIT + 12);
    elem(SHORT_LEN, CHAR_WAIT);
    check(vcount == 2, "R3 long gap splits count", vcount, 2);
    check(codes[0] == "E" && codes[1] == "E", "R3 long gap splits codes", int'(codes[1]), "E");
  endtask

  task automatic t_letters();
    expect_one("R4", ".-", "A");
    expect_one("R4", "-.", "N");
    expect_one("R4", "-.-", "K");
    expect_one("R4", "--.-", "Q");
    expect_one("R4", "...-", "V");
  endtask

  task automatic t_digits();
    expect_one("R5", ".....", "5");
    expect_one("R5", "-----", "0");
    expect_one("R5", ".----", "1");
    expect_one("R5", "---..", "8");
  endtask

  task automatic t_overlong();
    clear_mon();
    send("......");
    check(vcount == 0, "R6 six elements silent", vcount, 0);
    expect_one("R6 after overlong", "-", "T");
  endtask

  task automatic t_unmapped();
    clear_mon();
    send("..--");
    check(vcount == 0, "R7 unmapped silent", vcount, 0);
    expect_one("R7 after unmapped", ".", "E");
  endtask

  task automatic t_glitch();
    clear_mon();
    for (int i = 0; i < 5; i++) begin
      key_raw = 1'b1;
      repeat (2) @(negedge clk);
      key_raw = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (CHAR_WAIT) @(negedge clk);
    check(vcount == 0, "R1 bounce ignored", vcount, 0);
    check(char_ascii == "E", "R1 output untouched", int'(char_ascii), "E");
  endtask

  task automatic t_strobe();
    clear_mon();
    send("--..");
    check(doubles == 0, "R8 strobe one cycle", doubles, 0);
    check(vcount == 1 && codes[0] == "Z", "R8 code Z", int'(codes[0]), "Z");
    repeat (200) @(negedge clk);
    check(char_ascii == "Z", "R8 data held", int'(char_ascii), "Z");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_gap();
    t_letters();
    t_digits();
    t_overlong();
    t_unmapped();
    t_glitch();
    t_strobe();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule